// File: doc/BRIEF.md
# Opcode-in-Address Register Bridge

This block sits on a simple synchronous host port and fronts a bank of 32-bit target registers that it holds itself. A host access carries an operation code in its upper address bits. The same register can be reached through several address windows. One window gives plain reads and writes. Others turn a write into an atomic bit-set, an atomic bit-clear, or a masked update of one nibble, byte or halfword. In a masked update the mask and the data travel together in one write word. The block does the read-modify-write internally, so the host never needs a read before a write.

Every request is taken in the cycle its valid strobe is high. The response follows one clock later as a one-cycle ready pulse, carrying read data or an error flag. An access that the block cannot perform is refused as a whole: no register changes, and the error flag is raised.

Top module: `opaddr_reg_bridge`

## Requirements
- R1: Reset (rst_n low) clears every target register to zero and holds rsp_ready, rsp_error and rsp_rdata at zero.
- R2: Address bits [10:7] select the window: 0 plain access, 1 set, 2 clear, 4 nibble mask, 6 byte mask, 8 halfword mask. Any other code is an error. In the plain, set and clear windows, address bit 6 must be 0, otherwise the access is an error.
- R3: Every request with req_valid high produces rsp_ready high in the following cycle only. A request may be issued in every cycle.
- R4: Plain write: req_size 0 means byte, 1 means halfword, 2 means word. The operand sits in the low bits of req_wdata. The register index is addr[5:2], and the operand lands at byte lane addr[1:0]. A halfword needs addr[0]=0 and a word needs addr[1:0]=0. All bits outside the written lanes keep their value.
- R5: Set (byte, halfword or word, with the same lane placement as R4): every register bit whose placed operand bit is 1 becomes 1. All other bits are unchanged.
- R6: Clear (byte, halfword or word, with the same lane placement as R4): every register bit whose placed operand bit is 1 becomes 0. All other bits are unchanged.
- R7: Halfword mask window: the access must be a word with addr[1:0]=0. The index is addr[6:3]. addr[2]=0 targets register bits 15:0 and addr[2]=1 targets bits 31:16. req_wdata[31:16] is the mask and req_wdata[15:0] is the data.
- R8: Byte mask window: the access must be a halfword with addr[0]=0. The index is addr[6:3], and byte k=addr[2:1] is the target. req_wdata[15:8] is the mask and req_wdata[7:0] is the data.
- R9: Nibble mask window: the access must be a byte. The index is addr[6:3], and nibble k=addr[2:0] is the target. req_wdata[7:4] is the mask and req_wdata[3:0] is the data.
- R10: A read is served only through the plain window, as a byte or as an aligned halfword at lane addr[1:0]. The value comes back zero-extended in the low bits of rsp_rdata. A read never changes a register.
- R11: Any refused access changes no register and gives rsp_error=1 with rsp_rdata=0 in the response cycle. Refused accesses are: a read outside the plain window, a word read, req_size 3, a masked write of the wrong size, or a misaligned access.
- R12: In every masked write, a register bit takes the data bit only where the mask bit is 1. Successful writes return rsp_rdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 11 | Window code [10:7] and offset [6:0] |
| req_wdata | input | 32 | Write operand, or packed mask and data |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_error | output | 1 | Access refused |
| rsp_rdata | output | 32 | Zero-extended read data |

## Verification
The bench builds the block with its default of sixteen registers. With that value, every index a 4-bit field can carry decodes to a real register. The out-of-range index refusal that exists for smaller banks therefore cannot be reached, while every window, lane, nibble and halfword position of the full bank can. The reference model works bit by bit on integer offsets, and the whole bank is read back through the plain window at the end.

// File: rtl/orb_pkg.sv
package orb_pkg;
  localparam int ADDR_W = 11;
  localparam int REG_W  = 32;
  localparam int IDX_W  = 4;

  typedef enum logic [2:0] {
    OP_DIRECT, OP_SET, OP_CLEAR, OP_MASK4, OP_MASK8, OP_MASK16, OP_NONE
  } op_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // window code -> operation
  function automatic op_e region_of(input logic [3:0] code);
    case (code)
      4'd0:    return OP_DIRECT;
      4'd1:    return OP_SET;
      4'd2:    return OP_CLEAR;
      4'd4:    return OP_MASK4;
      4'd6:    return OP_MASK8;
      4'd8:    return OP_MASK16;
      default: return OP_NONE;
    endcase
  endfunction

  function automatic logic misaligned(input logic [1:0] size, input logic [1:0] off);
    case (size)
      SZ_HALF: return off[0];
      SZ_WORD: return off != 2'd0;
      default: return 1'b0;
    endcase
  endfunction

  // operand moved onto its byte lanes
  function automatic logic [REG_W-1:0] lane_fill(input logic [1:0] size,
      input logic [1:0] off, input logic [REG_W-1:0] operand);
    case (size)
      SZ_BYTE: return {24'd0, operand[7:0]} << {off, 3'b000};
      SZ_HALF: return {16'd0, operand[15:0]} << {off[1], 4'b0000};
      default: return operand;
    endcase
  endfunction

  // all-ones over the lanes an access covers
  function automatic logic [REG_W-1:0] lane_span(input logic [1:0] size,
      input logic [1:0] off);
    case (size)
      SZ_BYTE: return 32'h0000_00FF << {off, 3'b000};
      SZ_HALF: return 32'h0000_FFFF << {off[1], 4'b0000};
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // lane extraction for reads, zero-extended
  function automatic logic [REG_W-1:0] lane_pick(input logic [1:0] size,
      input logic [1:0] off, input logic [REG_W-1:0] word);
    logic [REG_W-1:0] sh;
    sh = word >> {off, 3'b000};
    if (size == SZ_BYTE) return {24'd0, sh[7:0]};
    return {16'd0, sh[15:0]};
  endfunction
endpackage

// File: rtl/orb_decode.sv
module orb_decode
  import orb_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic              wr,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output op_e               op,
  output logic [IDX_W-1:0]  idx,
  output logic              err,
  output logic [REG_W-1:0]  bit_en,
  output logic [REG_W-1:0]  bit_val
);
  logic             shape_err;
  logic             range_err;
  logic [REG_W-1:0] placed;
  logic [REG_W-1:0] span;

  assign op     = region_of(addr[10:7]);
  assign placed = lane_fill(size, addr[1:0], wdata);
  assign span   = lane_span(size, addr[1:0]);

  always_comb begin
    shape_err = 1'b0;
    idx       = addr[5:2];
    bit_en    = '0;
    bit_val   = '0;
    case (op)
      OP_DIRECT, OP_SET, OP_CLEAR: begin
        idx = addr[5:2];
        if (addr[6] || size == 2'd3 || misaligned(size, addr[1:0]))
          shape_err = 1'b1;
        else if (!wr)
          shape_err = (op != OP_DIRECT) || (size == SZ_WORD);
        else if (op == OP_DIRECT) begin
          bit_en  = span;
          bit_val = placed;
        end else if (op == OP_SET) begin
          bit_en  = placed;
          bit_val = '1;
        end else begin
          bit_en  = placed;
          bit_val = '0;
        end
      end
      OP_MASK16: begin
        idx       = addr[6:3];
        shape_err = !wr || size != SZ_WORD || addr[1:0] != 2'd0;
        bit_en    = {16'd0, wdata[31:16]} << {addr[2], 4'b0000};
        bit_val   = {16'd0, wdata[15:0]}  << {addr[2], 4'b0000};
      end
      OP_MASK8: begin
        idx       = addr[6:3];
        shape_err = !wr || size != SZ_HALF || addr[0];
        bit_en    = {24'd0, wdata[15:8]} << {addr[2:1], 3'b000};
        bit_val   = {24'd0, wdata[7:0]}  << {addr[2:1], 3'b000};
      end
      OP_MASK4: begin
        idx       = addr[6:3];
        shape_err = !wr || size != SZ_BYTE;
        bit_en    = {28'd0, wdata[7:4]} << {addr[2:0], 2'b00};
        bit_val   = {28'd0, wdata[3:0]} << {addr[2:0], 2'b00};
      end
      default: shape_err = 1'b1;
    endcase
  end

  generate
    if (NUM_REGS < (1 << IDX_W)) begin : g_range
      assign range_err = {1'b0, idx} >= (IDX_W+1)'(NUM_REGS);
    end else begin : g_full
      assign range_err = 1'b0;
    end
  endgenerate

  assign err = shape_err || range_err;
endmodule

// File: rtl/orb_regbank.sv
module orb_regbank
  import orb_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_go,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [REG_W-1:0]          bit_en,
  input  logic [REG_W-1:0]          bit_val,
  output logic [NUM_REGS*REG_W-1:0] bank_flat
);
  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic [REG_W-1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n)
          r <= '0;
        else if (wr_go && wr_idx == IDX_W'(g))
          r <= (r & ~bit_en) | (bit_val & bit_en);
      end
      assign bank_flat[g*REG_W +: REG_W] = r;
    end
  endgenerate
endmodule

// File: rtl/orb_readsel.sv
module orb_readsel
  import orb_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic [NUM_REGS*REG_W-1:0] bank_flat,
  input  logic [IDX_W-1:0]          idx,
  input  logic [1:0]                size,
  input  logic [1:0]                off,
  output logic [REG_W-1:0]          rd_val
);
  logic [REG_W-1:0] rd_word;

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (idx == IDX_W'(i)) rd_word = bank_flat[i*REG_W +: REG_W];
  end

  assign rd_val = lane_pick(size, off, rd_word);
endmodule

// File: rtl/opaddr_reg_bridge.sv
module opaddr_reg_bridge
  import orb_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [10:0]       req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_ready,
  output logic              rsp_error,
  output logic [31:0]       rsp_rdata
);
  op_e                       dec_op;
  logic [IDX_W-1:0]          dec_idx;
  logic                      dec_err;
  logic [REG_W-1:0]          dec_en;
  logic [REG_W-1:0]          dec_val;
  logic [NUM_REGS*REG_W-1:0] bank_flat;
  logic [REG_W-1:0]          rd_val;

  // named events for the checker
  logic acc_err;
  logic wr_go;
  logic rd_ok;

  assign acc_err = req_valid && dec_err;
  assign wr_go   = req_valid && req_write && !dec_err;
  assign rd_ok   = req_valid && !req_write && !dec_err;

  orb_decode #(.NUM_REGS(NUM_REGS)) u_dec (
    .wr      (req_write),
    .size    (req_size),
    .addr    (req_addr),
    .wdata   (req_wdata),
    .op      (dec_op),
    .idx     (dec_idx),
    .err     (dec_err),
    .bit_en  (dec_en),
    .bit_val (dec_val)
  );

  orb_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_go     (wr_go),
    .wr_idx    (dec_idx),
    .bit_en    (dec_en),
    .bit_val   (dec_val),
    .bank_flat (bank_flat)
  );

  orb_readsel #(.NUM_REGS(NUM_REGS)) u_rsel (
    .bank_flat (bank_flat),
    .idx       (dec_idx),
    .size      (req_size),
    .off       (req_addr[1:0]),
    .rd_val    (rd_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_ready <= 1'b0;
      rsp_error <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_ready <= req_valid;
      rsp_error <= acc_err;
      rsp_rdata <= rd_ok ? rd_val : '0;
    end
  end
endmodule

// File: rtl/orb_checker.sv
module orb_checker
  import orb_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_write,
  input logic [1:0]                req_size,
  input op_e                       dec_op,
  input logic                      acc_err,
  input logic                      wr_go,
  input logic                      rsp_ready,
  input logic                      rsp_error,
  input logic [31:0]               rsp_rdata,
  input logic [NUM_REGS*REG_W-1:0] bank_flat
);
  assert_ready_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_ready);

  assert_ready_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_ready);

  assert_bad_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dec_op == OP_NONE) |=> rsp_error);

  assert_refused_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> (rsp_error && bank_flat == $past(bank_flat)));

  assert_error_shape_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> (rsp_ready && rsp_rdata == '0));

  assert_read_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> bank_flat == $past(bank_flat));

  assert_byte_read_zx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !acc_err && req_size == SZ_BYTE) |=> rsp_rdata[31:8] == '0);

  assert_set_only_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && dec_op == OP_SET) |=> (($past(bank_flat) & ~bank_flat) == '0));

  assert_clear_only_lowers_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && dec_op == OP_CLEAR) |=> ((~$past(bank_flat) & bank_flat) == '0));
endmodule

bind opaddr_reg_bridge orb_checker #(.NUM_REGS(NUM_REGS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_size  (req_size),
  .dec_op    (dec_op),
  .acc_err   (acc_err),
  .wr_go     (wr_go),
  .rsp_ready (rsp_ready),
  .rsp_error (rsp_error),
  .rsp_rdata (rsp_rdata),
  .bank_flat (bank_flat)
);

// File: tb/opaddr_reg_bridge_tb.sv
`timescale 1ns/1ps
module opaddr_reg_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [10:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_ready;
  logic        rsp_error;
  logic [31:0] rsp_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] mdl [16];

  always #4 clk = ~clk;

  opaddr_reg_bridge #(.NUM_REGS(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata)
  );

  task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference: integer offsets, bit by bit
  task automatic model(input bit wr, input int sz, input int a, input logic [31:0] wd,
                       output bit e, output logic [31:0] rd);
    int region, off, r, bo, k;
    region = a / 128;
    off = a % 128;
    e = 0;
    rd = 0;
    if (region == 0 || region == 1 || region == 2) begin
      r = off / 4;
      bo = off % 4;
      if (off >= 64 || sz == 3 || (sz == 1 && bo % 2 != 0) || (sz == 2 && bo != 0)) e = 1;
      else if (!wr) begin
        if (region != 0 || sz == 2) e = 1;
        else rd = (mdl[r] >> (8 * bo)) & ((sz == 0) ? 32'hFF : 32'hFFFF);
      end else begin
        for (int b = 0; b < (1 << sz); b++)
          for (int i = 0; i < 8; i++) begin
            int t;
            t = 8 * (bo + b) + i;
            if (region == 0) mdl[r][t] = wd[8 * b + i];
            else if (region == 1 && wd[8 * b + i]) mdl[r][t] = 1'b1;
            else if (region == 2 && wd[8 * b + i]) mdl[r][t] = 1'b0;
          end
      end
    end else if (region == 4 || region == 6 || region == 8) begin
      r = off / 8;
      k = off % 8;
      if (!wr) e = 1;
      else if (region == 4) begin
        if (sz != 0) e = 1;
        else for (int i = 0; i < 4; i++) if (wd[4 + i]) mdl[r][4 * k + i] = wd[i];
      end else if (region == 6) begin
        if (sz != 1 || k % 2 != 0) e = 1;
        else for (int i = 0; i < 8; i++) if (wd[8 + i]) mdl[r][8 * (k / 2) + i] = wd[i];
      end else begin
        if (sz != 2 || k % 4 != 0) e = 1;
        else for (int i = 0; i < 16; i++) if (wd[16 + i]) mdl[r][16 * (k / 4) + i] = wd[i];
      end
    end else e = 1;
  endtask

  task automatic access(input string tag, input bit wr, input int sz, input int a,
                        input logic [31:0] wd);
    bit e;
    logic [31:0] rd;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_size  = 2'(sz);
    req_addr  = 11'(a);
    req_wdata = wd;
    model(wr, sz, a, wd, e, rd);
    @(posedge clk);
    #1;
    check(tag, {rsp_ready, rsp_error, rsp_rdata}, {1'b1, e, rd});
  endtask

  task automatic idle(input string tag);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    check(tag, {1'b0, rsp_ready, 32'd0}, 34'd0);
  endtask

  task automatic dump(input string tag);
    for (int r = 0; r < 16; r++) begin
      access(tag, 0, 1, 4 * r, 0);
      access(tag, 0, 1, 4 * r + 2, 0);
    end
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 outputs", {rsp_ready, rsp_error, rsp_rdata}, 34'd0);
    dump("R1 cleared bank");
    idle("R3 idle after burst");
    // plain writes
    access("R4 word", 1, 2, 'h00C, 32'h1234_5678);
    access("R4 half hi", 1, 1, 'h016, 32'h0000_ABCD);
    access("R4 half lo", 1, 1, 'h014, 32'h0000_EF01);
    access("R4 byte0", 1, 0, 'h01C, 32'h33);
    access("R4 byte1", 1, 0, 'h01D, 32'h44);
    access("R4 byte2", 1, 0, 'h01E, 32'h55);
    access("R4 byte3", 1, 0, 'h01F, 32'hFFFF_FF66);
    access("R10 byte read", 0, 0, 'h01E, 0);
    access("R10 half read", 0, 1, 'h00E, 0);
    // set and clear
    access("R5 word", 1, 2, 'h08C, 32'hAAAA_AAAA);
    access("R5 byte lane2", 1, 0, 'h096, 32'h55);
    access("R6 word", 1, 2, 'h10C, 32'h00FF_0000);
    access("R6 half hi", 1, 1, 'h11E, 32'h0000_F0F0);
    access("R5 readback", 0, 1, 'h00C, 0);
    access("R6 readback", 0, 1, 'h01E, 0);
    // masked writes to register 2
    access("R7 low half", 1, 2, 'h410, 32'hFFFF_5555);
    access("R7 high half", 1, 2, 'h414, 32'h01FF_01AA);
    access("R8 byte3", 1, 1, 'h316, 32'h0000_FF33);
    access("R12 byte0 partial", 1, 1, 'h310, 32'h0000_0F00);
    access("R9 nibble0", 1, 0, 'h210, 32'hF7);
    access("R12 nibble5 partial", 1, 0, 'h215, 32'hA4);
    access("R9 nibble7 reg15", 1, 0, 'h27F, 32'hF9);
    access("R7 reg15 hi", 1, 2, 'h47C, 32'hFFFF_BEEF);
    idle("R3 gap");
    // refused accesses
    access("R11 read via set", 0, 1, 'h08C, 0);
    access("R11 word read", 0, 2, 'h00C, 0);
    access("R11 mask16 half", 1, 1, 'h410, 32'hFFFF_0000);
    access("R11 mask8 byte", 1, 0, 'h310, 32'hFF);
    access("R11 mask8 odd", 1, 1, 'h311, 32'hFF00);
    access("R11 mask4 word", 1, 2, 'h210, 32'hF0);
    access("R11 misaligned half", 1, 1, 'h001, 32'hFFFF);
    access("R11 misaligned word", 1, 2, 'h006, 32'hFFFF_FFFF);
    access("R11 size3", 1, 3, 'h000, 32'hFFFF_FFFF);
    access("R11 mask16 read", 0, 2, 'h410, 0);
    access("R2 code3", 1, 2, 'h180, 32'hFFFF_FFFF);
    access("R2 bit6 plain", 1, 2, 'h040, 32'hFFFF_FFFF);
    access("R2 bit6 set", 1, 2, 'h0C0, 32'hFFFF_FFFF);
    access("R2 code10", 1, 2, 'h500, 32'hFFFF_FFFF);
    access("R2 top", 1, 0, 'h7FF, 32'hFF);
    access("R2 code5", 1, 0, 'h280, 32'hFF);
    idle("R3 end gap");
    dump("R10 final bank");
    idle("R3 tail");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule